// File: doc/BRIEF.md
# SPI Receive Status and Error Flags

This block holds the receive-side state of an SPI peripheral as a CPU sees it. It keeps a data register, three flags and three enable bits. The flags are receive-full, overrun and mode-fault. The shift logic raises a one-cycle strobe with each byte it has finished receiving, and a separate detector raises a one-cycle mode-fault pulse. The block turns those events into flags. It clears each flag only after a defined sequence of register accesses. It drives one shared interrupt request for all three flags.

The CPU does not write any flag directly. A status read records every flag that the read saw set; the flag is then armed. A later data read clears the receive-full and overrun flags that are armed. A later control write clears the mode-fault flag if it is armed. A flag that was set after the status read stays set. When a byte arrives while the previous byte is still unread, the new byte is dropped and the overrun flag is set. The older byte stays in the data register.

Top module: `spi_rx_status`

## Requirements
- R1: After reset, `rx_data_o` is 0x00, `flags_o` is 0, `ctrl_o` is 0 and `irq_o` is 0.
- R2: `rx_done_i` with the receive-full flag (`flags_o[0]`) clear loads `rx_byte_i` into `rx_data_o` and sets `flags_o[0]` on the next cycle.
- R3: `rx_done_i` while `flags_o[0]` is set, with no clearing data read in that cycle, sets the overrun flag (`flags_o[1]`), discards the byte and leaves `rx_data_o` unchanged.
- R4: `flags_o[0]` clears on `data_rd_i` only if a `stat_rd_i` that saw it set came earlier. A data read with nothing armed changes nothing.
- R5: `flags_o[1]` clears on `data_rd_i` only if the latest `stat_rd_i` saw it set. A data read after a status read that saw it clear leaves it set.
- R6: A flag set after the latest status read is not cleared by the data read or control write that follows.
- R7: The mode-fault flag (`flags_o[2]`) is set by `mode_fault_i` only while the stored enable `ctrl_o[2]` is 1.
- R8: Writing `ctrl_o[2]` to 0 does not clear `flags_o[2]`. It clears only on `ctrl_wr_i` after a status read that saw it set.
- R9: `irq_o` = (`flags_o[0]` and `ctrl_o[0]`) or (`ctrl_o[1]` and (`flags_o[1]` or `flags_o[2]`)). `ctrl_o[1]` is the single enable for both error flags.
- R10: A byte that completes in the same cycle as a data read that clears receive-full is loaded, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_done_i | input | 1 | Strobe: a received byte is complete |
| rx_byte_i | input | DATA_W | The completed byte |
| mode_fault_i | input | 1 | Mode-fault detect pulse |
| stat_rd_i | input | 1 | CPU reads the status register |
| data_rd_i | input | 1 | CPU reads the data register |
| ctrl_wr_i | input | 1 | CPU writes the control register |
| ctrl_wdata_i | input | 3 | Write data: [0] receive irq enable, [1] error irq enable, [2] mode-fault enable |
| rx_data_o | output | DATA_W | Data register |
| flags_o | output | 3 | [0] receive-full, [1] overrun, [2] mode-fault |
| ctrl_o | output | 3 | Stored enable bits, same layout as ctrl_wdata_i |
| irq_o | output | 1 | Combined receiver/error interrupt request |

## Verification
The assertions assume that each bus access is a single-cycle pulse. They also assume that a status read never falls in the same cycle as a data read or control write, so the state that arms a clear is always settled before the clear happens. The table stimulus issues at most one access or event per cycle. Only the R10 directed case deliberately overlaps a byte strobe with a data read, and that combination is inside what the assertions allow.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int unsigned NFLAG = 3;
  localparam int unsigned F_FULL = 0;
  localparam int unsigned F_OVR  = 1;
  localparam int unsigned F_MODF = 2;

  typedef struct packed {
    logic modf_en;
    logic err_ie;
    logic rx_ie;
  } ctrl_t;
endpackage

// File: rtl/spi_rx_flags.sv
module spi_rx_flags
  import spi_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_done_i,
  input  logic             fault_i,
  input  logic             modf_en_i,
  input  logic             stat_rd_i,
  input  logic             data_rd_i,
  input  logic             ctrl_wr_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             load_o
);
  logic [NFLAG-1:0] flag_q, flag_d, arm_q, clr;
  logic             full_eff;

  // data read retires full/overrun arms, control write retires mode-fault arm
  logic [NFLAG-1:0] retire;
  assign retire[F_FULL] = data_rd_i;
  assign retire[F_OVR]  = data_rd_i;
  assign retire[F_MODF] = ctrl_wr_i;

  for (genvar i = 0; i < NFLAG; i++) begin : g_arm
    assign clr[i] = retire[i] & arm_q[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        arm_q[i] <= 1'b0;
      else if (stat_rd_i) arm_q[i] <= flag_q[i];
      else if (retire[i]) arm_q[i] <= 1'b0;
    end
  end

  assign full_eff = flag_q[F_FULL] & ~clr[F_FULL];
  assign load_o   = rx_done_i & ~full_eff;

  always_comb begin
    flag_d[F_FULL] = full_eff | load_o;
    flag_d[F_OVR]  = (flag_q[F_OVR] & ~clr[F_OVR]) | (rx_done_i & full_eff);
    flag_d[F_MODF] = (flag_q[F_MODF] & ~clr[F_MODF]) | (fault_i & modf_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/spi_rx_dreg.sv
module spi_rx_dreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_o <= '0;
    else if (load_i) data_o <= byte_i;
  end
endmodule

// File: rtl/spi_rx_irq.sv
module spi_rx_irq
  import spi_rx_pkg::*;
(
  input  logic [NFLAG-1:0] flags_i,
  input  ctrl_t            ctrl_i,
  output logic             irq_o
);
  logic err_any;
  assign err_any = flags_i[F_OVR] | flags_i[F_MODF];
  assign irq_o   = (flags_i[F_FULL] & ctrl_i.rx_ie) | (ctrl_i.err_ie & err_any);
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              mode_fault_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  input  logic              ctrl_wr_i,
  input  logic [NFLAG-1:0]  ctrl_wdata_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [NFLAG-1:0]  flags_o,
  output logic [NFLAG-1:0]  ctrl_o,
  output logic              irq_o
);
  ctrl_t ctrl_q;
  logic  load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_wr_i) ctrl_q <= ctrl_t'(ctrl_wdata_i);
  end
  assign ctrl_o = ctrl_q;

  spi_rx_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_done_i (rx_done_i),
    .fault_i   (mode_fault_i),
    .modf_en_i (ctrl_q.modf_en),
    .stat_rd_i (stat_rd_i),
    .data_rd_i (data_rd_i),
    .ctrl_wr_i (ctrl_wr_i),
    .flags_o   (flags_o),
    .load_o    (load)
  );

  spi_rx_dreg #(.DATA_W(DATA_W)) u_dreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .byte_i (rx_byte_i),
    .data_o (rx_data_o)
  );

  spi_rx_irq u_irq (
    .flags_i (flags_o),
    .ctrl_i  (ctrl_q),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/spi_rx_status_chk.sv
module spi_rx_status_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_done_i,
  input logic [DATA_W-1:0] rx_byte_i,
  input logic              mode_fault_i,
  input logic              data_rd_i,
  input logic              ctrl_wr_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic [2:0]        flags_o,
  input logic [2:0]        ctrl_o,
  input logic              irq_o
);
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i && !flags_o[0] |=> flags_o[0] && rx_data_o == $past(rx_byte_i));

  p_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i && flags_o[0] && !data_rd_i |=> flags_o[1] && flags_o[0] && $stable(rx_data_o));

  p_full_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[0] && !data_rd_i |=> flags_o[0]);

  p_ovr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[1] && !data_rd_i |=> flags_o[1]);

  p_modf_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_o[2] && !(mode_fault_i && ctrl_o[2]) |=> !flags_o[2]);

  p_modf_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[2] && !ctrl_wr_i |=> flags_o[2]);

  p_irq_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[1:0] == 2'b00 |-> !irq_o);

  p_irq_rx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[0] && ctrl_o[0] |-> irq_o);

  p_irq_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[1] || flags_o[2]) && ctrl_o[1] |-> irq_o);
endmodule

bind spi_rx_status spi_rx_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_done_i    (rx_done_i),
  .rx_byte_i    (rx_byte_i),
  .mode_fault_i (mode_fault_i),
  .data_rd_i    (data_rd_i),
  .ctrl_wr_i    (ctrl_wr_i),
  .rx_data_o    (rx_data_o),
  .flags_o      (flags_o),
  .ctrl_o       (ctrl_o),
  .irq_o        (irq_o)
);

// File: tb/spi_rx_status_tb.sv
module spi_rx_status_tb;
  localparam int unsigned DW = 8;
  localparam int unsigned NV = 24;

  // one cycle of stimulus and the state expected after it
  typedef struct packed {
    logic          rxd;
    logic [DW-1:0] b;
    logic          sr;
    logic          dr;
    logic          cw;
    logic [2:0]    cwd;
    logic          mf;
    logic [2:0]    ef;
    logic [DW-1:0] ed;
    logic [3:0]    req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 3'b001, 8'hA5, 4'd2},  // R2 load
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 3'b001, 8'hA5, 4'd4},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, 8'hA5, 4'd4},  // R4 clear
    '{1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 3'b001, 8'h3C, 4'd2},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 3'b001, 8'h3C, 4'd4},  // R4 unarmed read
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 3'b001, 8'h3C, 4'd4},
    '{1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 3'b011, 8'h3C, 4'd3},  // R3 drop
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 3'b010, 8'h3C, 4'd5},  // R5 ovr stays
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 3'b010, 8'h3C, 4'd5},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, 8'h3C, 4'd5},  // R5 ovr clear
    '{1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 3'b001, 8'h11, 4'd2},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 3'b001, 8'h11, 4'd6},
    '{1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 3'b011, 8'h11, 4'd3},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 3'b010, 8'h11, 4'd6},  // R6 late ovr kept
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 3'b010, 8'h11, 4'd5},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, 8'h11, 4'd5},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 3'b000, 8'h11, 4'd7},  // R7 gated off
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 3'b100, 1'b0, 3'b000, 8'h11, 4'd7},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 3'b100, 8'h11, 4'd7},  // R7 set
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 3'b100, 8'h11, 4'd8},  // R8 enable off keeps
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 3'b100, 8'h11, 4'd8},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 3'b100, 8'h11, 4'd8},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 3'b000, 8'h11, 4'd8},  // R8 clear
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 3'b000, 8'h11, 4'd7}   // R7 not set again
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rx_done_i = 1'b0;
  logic [DW-1:0] rx_byte_i = '0;
  logic          mode_fault_i = 1'b0;
  logic          stat_rd_i = 1'b0;
  logic          data_rd_i = 1'b0;
  logic          ctrl_wr_i = 1'b0;
  logic [2:0]    ctrl_wdata_i = '0;
  logic [DW-1:0] rx_data_o;
  logic [2:0]    flags_o;
  logic [2:0]    ctrl_o;
  logic          irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  spi_rx_status #(.DATA_W(DW)) u_dut (
    .clk_i, .rst_ni, .rx_done_i, .rx_byte_i, .mode_fault_i,
    .stat_rd_i, .data_rd_i, .ctrl_wr_i, .ctrl_wdata_i,
    .rx_data_o, .flags_o, .ctrl_o, .irq_o
  );

  task automatic chk(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, remove at the next, outputs then settled
  task automatic step(input logic rxd, input logic [DW-1:0] b, input logic sr,
                      input logic dr, input logic cw, input logic [2:0] cwd, input logic mf);
    rx_done_i = rxd; rx_byte_i = b; stat_rd_i = sr; data_rd_i = dr;
    ctrl_wr_i = cw; ctrl_wdata_i = cwd; mode_fault_i = mf;
    @(negedge clk_i);
    rx_done_i = 0; stat_rd_i = 0; data_rd_i = 0; ctrl_wr_i = 0; mode_fault_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(1, "data", 16'(rx_data_o), 16'h0);
    chk(1, "flags", 16'(flags_o), 16'h0);
    chk(1, "ctrl", 16'(ctrl_o), 16'h0);
    chk(1, "irq", 16'(irq_o), 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].rxd, VEC[i].b, VEC[i].sr, VEC[i].dr, VEC[i].cw, VEC[i].cwd, VEC[i].mf);
      chk(int'(VEC[i].req), $sformatf("vec %0d flags", i), 16'(flags_o), 16'(VEC[i].ef));
      chk(int'(VEC[i].req), $sformatf("vec %0d data", i), 16'(rx_data_o), 16'(VEC[i].ed));
    end

    // R9 interrupt combining
    step(0, 0, 0, 0, 1, 3'b001, 0);
    chk(9, "irq idle", 16'(irq_o), 16'h0);
    step(1, 8'h55, 0, 0, 0, 0, 0);
    chk(9, "irq rx_ie full", 16'(irq_o), 16'h1);
    step(0, 0, 0, 0, 1, 3'b010, 0);
    chk(9, "irq err_ie only full", 16'(irq_o), 16'h0);
    step(1, 8'h66, 0, 0, 0, 0, 0);
    chk(9, "irq err_ie ovr", 16'(irq_o), 16'h1);
    step(0, 0, 0, 0, 1, 3'b000, 0);
    chk(9, "irq all off", 16'(irq_o), 16'h0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    chk(5, "cleanup flags", 16'(flags_o), 16'h0);
    step(0, 0, 0, 0, 1, 3'b110, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    chk(9, "irq err_ie modf", 16'(irq_o), 16'h1);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 3'b000, 0);
    chk(8, "modf cleared", 16'(flags_o), 16'h0);

    // R10 byte arriving with the clearing data read
    step(1, 8'h9A, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(1, 8'hC3, 0, 1, 0, 0, 0);
    chk(10, "flags same cycle", 16'(flags_o), 16'h1);
    chk(10, "data same cycle", 16'(rx_data_o), 16'hC3);

    // R1 reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(1, "flags after reset", 16'(flags_o), 16'h0);
    chk(1, "data after reset", 16'(rx_data_o), 16'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule